// File: doc/BRIEF.md
# Prescaled Event Timer

An 8-bit up-counting timer whose count source is either a per-instruction-cycle enable or transitions on an external pin. A power-of-two divider can sit in front of the counter. The same divider can instead be handed to a watchdog tick path, and then the timer runs undivided. Software sets the timer through a single write port. One byte of option bits picks the source, the active pin edge, the divider owner and the ratio. The current count is always readable.

Any write to the count clears the divider while the divider belongs to the timer. This way a newly loaded value starts a full divided period. A watchdog clear empties the divider when the watchdog owns it. Software never sees or sets the divider directly. An overflow from 0xFF to 0x00 sets a sticky flag, which stays set until a separate clear input is pulsed.

Top module: `tmr_prescaled`

## Requirements
- R1: After reset the count is 0x00 and the overflow flag is 0. The option bits reset to 0x3F, so the source is the external pin, the edge is falling, the divider belongs to the watchdog (`presc_to_wdt`=1) and the ratio is 1:128. In this state `tick_en` pulses do not change the count.
- R2: With option bit 5 at 0 and no division, the count rises by one on the clock edge after each cycle in which `tick_en` is high.
- R3: With option bit 5 at 1, the counter counts transitions of `ext_in` after a two-flop synchroniser. Option bit 4 at 0 selects rising edges and 1 selects falling edges. `tick_en` is ignored in this mode.
- R4: With option bit 3 at 0, option bits 2:0 holding code n divide the selected source by 2^n (1:1 up to 1:128).
- R5: With option bit 3 at 1, `presc_to_wdt` is 1, the timer counts every source event, and `wdt_tick_out` fires once per 2^n `wdt_tick_in` pulses. With bit 3 at 0, `wdt_tick_out` follows `wdt_tick_in` undivided.
- R6: A cycle with `wr_cnt` high loads `wr_data` into the count on the next edge. The write takes priority over an increment in the same cycle, and it never sets the overflow flag.
- R7: A count write clears the divider when option bit 3 is 0. It leaves the divider alone when bit 3 is 1.
- R8: `wdt_clr` clears the divider when option bit 3 is 1. It has no effect when bit 3 is 0.
- R9: An increment from 0xFF to 0x00 sets `ovf_flag`. The flag holds until `ovf_clr` is pulsed. A set in the same cycle as a clear wins.
- R10: `wr_opt` loads `wr_data[5:0]` as the new option bits. Bits 7:6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Instruction-cycle enable (internal source) |
| ext_in | input | 1 | Asynchronous external count pin |
| wr_cnt | input | 1 | Write strobe for the count |
| wr_opt | input | 1 | Write strobe for the option bits |
| wr_data | input | 8 | Write data for either strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_tick_in | input | 1 | Base watchdog tick |
| wdt_clr | input | 1 | Watchdog clear request |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick_out | output | 1 | Watchdog tick after optional division |
| presc_to_wdt | output | 1 | High while the divider is owned by the watchdog |

## Verification
The bench goes after the divider's hidden state. It leaves the divider part-filled, then writes the count or pulses the watchdog clear, and checks how many further events the next step needs. A design that forgets either clear, or applies it to the wrong owner, is off by one step. It also checks that a write in the same cycle as a tick keeps the written value, and that a set and a clear of the overflow flag in one cycle leave the flag set. It walks both pin edges and several ratios; a swapped edge decode or a ratio off by one power shows up as a wrong count.

// File: rtl/tmr_prescaled.sv
module tmr_prescaled #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ext_in,
  input  logic             wr_cnt,
  input  logic             wr_opt,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_clr,
  input  logic             wdt_tick_in,
  input  logic             wdt_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag,
  output logic             wdt_tick_out,
  output logic             presc_to_wdt
);
  localparam int OPT_W = SEL_W + 3;
  localparam logic [OPT_W-1:0] OPT_RST = '1;

  logic [OPT_W-1:0] opt_q;
  logic [2:0]       sync_q;
  logic [PS_W-1:0]  ps_cnt, ps_mask;
  logic             src_sel, edge_sel, ps_wdt;
  logic             ext_ev, src_ev, ps_event, ps_hit, ps_clr, cnt_inc;

  assign src_sel  = opt_q[SEL_W+2];
  assign edge_sel = opt_q[SEL_W+1];
  assign ps_wdt   = opt_q[SEL_W];
  assign presc_to_wdt = ps_wdt;

  always_ff @(posedge clk) begin
    if (!rst_n) opt_q <= OPT_RST;
    else if (wr_opt) opt_q <= wr_data[OPT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else sync_q <= {sync_q[1:0], ext_in};
  end

  assign ext_ev = edge_sel ? (~sync_q[1] & sync_q[2]) : (sync_q[1] & ~sync_q[2]);
  assign src_ev = src_sel ? ext_ev : tick_en;

  assign ps_mask  = ~({PS_W{1'b1}} << opt_q[SEL_W-1:0]);
  assign ps_hit   = (ps_cnt & ps_mask) == ps_mask;
  assign ps_event = ps_wdt ? wdt_tick_in : src_ev;
  assign ps_clr   = ps_wdt ? wdt_clr : wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ps_cnt <= '0;
    else if (ps_clr) ps_cnt <= '0;
    else if (ps_event) ps_cnt <= ps_cnt + 1'b1;
  end

  assign cnt_inc      = src_ev & (ps_wdt | ps_hit);
  assign wdt_tick_out = wdt_tick_in & (~ps_wdt | ps_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else if (!wr_cnt && cnt_inc && (&cnt_q)) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wr_data)); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_UNDIV_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_wdt && !src_sel && tick_en && !wr_cnt && !wr_opt) |=> cnt_q == $past(cnt_q) + 1'b1); // R5
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R9
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && (&cnt_q)) |=> (cnt_q != '0 || ovf_flag)); // R9
  AST_PS_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !ps_wdt) |=> ps_cnt == '0); // R7
  AST_PS_WDT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr && ps_wdt) |=> ps_cnt == '0); // R8
endmodule

// File: tb/tb_tmr_prescaled.sv
module tb_tmr_prescaled;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick_en = 0, ext_in = 0, wr_cnt = 0, wr_opt = 0;
  logic [7:0] wr_data = '0;
  logic ovf_clr = 0, wdt_tick_in = 0, wdt_clr = 0;
  logic [7:0] cnt_q;
  logic ovf_flag, wdt_tick_out, presc_to_wdt;
  int n_chk = 0, n_fail = 0, outs = 0;

  tmr_prescaled dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_in(ext_in),
    .wr_cnt(wr_cnt), .wr_opt(wr_opt), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .wdt_tick_in(wdt_tick_in), .wdt_clr(wdt_clr), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
    .wdt_tick_out(wdt_tick_out), .presc_to_wdt(presc_to_wdt));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {option[5:0], tick count, expected count}
  localparam logic [21:0] VEC [6] = '{
    {6'b000000, 8'd5,   8'd5},
    {6'b000001, 8'd6,   8'd3},
    {6'b000011, 8'd20,  8'd2},
    {6'b000111, 8'd200, 8'd1},
    {6'b001111, 8'd9,   8'd9},
    {6'b000010, 8'd4,   8'd1}
  };

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    @(negedge clk) tick_en = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) tick_en = 0;
  endtask

  task automatic write_cnt(input logic [7:0] v);
    @(negedge clk) begin wr_cnt = 1; wr_data = v; end
    @(negedge clk) wr_cnt = 0;
  endtask

  task automatic write_opt(input logic [7:0] v);
    @(negedge clk) begin wr_opt = 1; wr_data = v; end
    @(negedge clk) wr_opt = 0;
  endtask

  task automatic pulse_wdt_clr();
    @(negedge clk) wdt_clr = 1;
    @(negedge clk) wdt_clr = 0;
  endtask

  task automatic ext_set(input logic v);
    @(negedge clk) ext_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wdt_pulses(input int n);
    outs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wdt_tick_in = 1;
      #2 if (wdt_tick_out) outs++;
    end
    @(negedge clk) wdt_tick_in = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count", cnt_q, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 owner", presc_to_wdt, 1);
    tick(3);
    check("R1 ticks ignored", cnt_q, 0);

    for (int i = 0; i < 6; i++) begin
      write_opt({2'b00, VEC[i][21:16]});
      write_cnt(8'h00);
      tick(int'(VEC[i][15:8]));
      check("R2/R4/R5 vector", cnt_q, int'(VEC[i][7:0]));
    end

    // R9 wrap, sticky, clear
    write_opt(8'h00);
    write_cnt(8'hFE);
    tick(1);
    check("R9 no flag at FF", ovf_flag, 0);
    tick(1);
    check("R9 wrap count", cnt_q, 0);
    check("R9 flag set", ovf_flag, 1);
    tick(3);
    check("R9 sticky", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    check("R9 cleared", ovf_flag, 0);
    write_cnt(8'hFF);
    @(negedge clk) begin tick_en = 1; ovf_clr = 1; end
    @(negedge clk) begin tick_en = 0; ovf_clr = 0; end
    check("R9 set beats clear", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;

    // R6 write priority at wrap
    write_cnt(8'hFF);
    @(negedge clk) begin tick_en = 1; wr_cnt = 1; wr_data = 8'h10; end
    @(negedge clk) begin tick_en = 0; wr_cnt = 0; end
    check("R6 write wins", cnt_q, 8'h10);
    check("R6 no flag", ovf_flag, 0);

    // R7 write clears the timer divider
    write_opt(8'h02);
    write_cnt(8'h00);
    tick(3);
    write_cnt(8'h00);
    tick(3);
    check("R7 divider cleared", cnt_q, 0);
    tick(1);
    check("R7 fourth tick", cnt_q, 1);

    // R8 watchdog clear ignored for the timer
    write_cnt(8'h00);
    tick(3);
    pulse_wdt_clr();
    tick(1);
    check("R8 clear ignored", cnt_q, 1);

    // R3 external edges
    write_opt(8'h28);
    write_cnt(8'h00);
    ext_set(1);
    check("R3 rising", cnt_q, 1);
    ext_set(0);
    check("R3 fall ignored", cnt_q, 1);
    tick(2);
    check("R3 tick ignored", cnt_q, 1);
    write_opt(8'h38);
    write_cnt(8'h00);
    ext_set(1);
    check("R3 rise ignored", cnt_q, 0);
    ext_set(0);
    check("R3 falling", cnt_q, 1);
    write_opt(8'h21);
    write_cnt(8'h00);
    for (int i = 0; i < 4; i++) begin ext_set(1); ext_set(0); end
    check("R3/R4 divided edges", cnt_q, 2);

    // R5/R8 watchdog path
    write_opt(8'h0A);
    check("R5 owner", presc_to_wdt, 1);
    pulse_wdt_clr();
    wdt_pulses(8);
    check("R5 divided wdt", outs, 2);
    wdt_pulses(3);
    pulse_wdt_clr();
    wdt_pulses(3);
    check("R8 wdt clear", outs, 0);
    wdt_pulses(1);
    check("R8 after clear", outs, 1);
    wdt_pulses(3);
    write_cnt(8'h00);
    wdt_pulses(1);
    check("R7 write keeps wdt divider", outs, 1);
    write_opt(8'h02);
    check("R5 owner timer", presc_to_wdt, 0);
    wdt_pulses(3);
    check("R5 undivided wdt", outs, 3);

    // R10 upper bits ignored
    write_opt(8'hC0);
    write_cnt(8'h00);
    tick(2);
    check("R10 upper bits", cnt_q, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule